// File: doc/BRIEF.md
# Barrel Hardware Thread Issue Scheduler

This block decides, every clock, which of up to eight hardware threads may send an instruction into a core whose pipeline is four stages deep. A thread cannot issue again until its previous instruction has left the pipeline, so each thread gets at most one issue slot in any four consecutive clocks. When four or fewer threads are runnable, each one runs at that full rate and the spare slots become idle bubbles. When five to eight are runnable, the slots are handed out in strict rotation, so each of N threads gets one slot in every N clocks.

The surrounding core presents one enable bit per thread and takes back an issue flag with a thread index. The choice is combinational from the block's state and the current enable mask. Each thread has a small cooldown counter that is loaded when the thread issues. A rotation pointer makes the grant fair: the search starts at the thread after the last one that issued and proceeds in ascending index order, wrapping around.

Top module: `barrel_sched`

## Requirements
- R1: After reset the rotation pointer is at thread 0 and all cooldowns are clear. No issue occurs while the enable mask is zero. The first issue after reset goes to the lowest-numbered enabled thread.
- R2: A given thread never issues twice within four consecutive clocks. After an issue at clock t, the earliest next issue for that thread is at clock t+4.
- R3: With N enabled threads, N from 1 to 4, and a fixed mask, each thread issues exactly once in every 4 clocks. The remaining 4-N clocks of each period have `issue_valid` = 0.
- R4: With N enabled threads, N from 5 to 8, and a fixed mask, `issue_valid` stays 1 and each thread issues exactly once in every N clocks.
- R5: Grants go in ascending thread index order, wrapping from the highest index to 0. The search begins at the thread after the last one granted, and disabled threads are skipped. This holds for enable masks whose bits are not contiguous.
- R6: Only a thread whose bit in `thread_active` is 1 can be granted. Bit i of `thread_active` enables thread i. `issue_tid` is the binary index of the granted thread. A thread cleared from the mask is not granted in any cycle in which its bit is 0.
- R7: A thread's cooldown keeps running while the thread is disabled. A thread re-enabled less than four clocks after its last issue must wait until four clocks have passed since that issue.
- R8: Whenever some enabled thread has not issued in the last three clocks, `issue_valid` is 1 in that cycle. A newly enabled thread that has never issued is eligible at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thread_active | input | NUM_THREADS | Per-thread enable mask; bit i is thread i |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | $clog2(NUM_THREADS) | Index of the issuing thread (valid when issue_valid is 1) |

## Verification
Two functions can land in the same cycle: the rotation pointer reaching a thread, and that thread's enable bit or cooldown ruling it out. The bench provokes this in two ways. It removes a thread from the mask in the very cycle the rotation would pick it. It also re-enables a thread one clock before its cooldown ends, so that the pointer has already wrapped onto it. It judges the results by the granted index and by the bubble that must appear, both computed from the requirements. The checker independently counts the clocks since each thread's last issue and ties them to spacing and to the rule that no bubble appears while work is waiting.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;
   localparam int unsigned MAX_THREADS = 8;
   localparam int unsigned MIN_THREADS = 2;

   // Width of a counter that must hold the value n-1 (at least one bit).
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/thread_cooldown.sv
module thread_cooldown #(
   parameter int unsigned PIPE_DEPTH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic issued,
   output logic ready
);
   localparam int unsigned CW = barrel_sched_pkg::cnt_width(PIPE_DEPTH);

   generate
      if (PIPE_DEPTH <= 1) begin : g_nocool
         assign ready = 1'b1;
      end else begin : g_cool
         logic [CW-1:0] remain;
         always_ff @(posedge clk) begin
            if (rst) begin
               remain <= '0;
            end else if (issued) begin
               remain <= CW'(PIPE_DEPTH - 1);
            end else if (remain != '0) begin
               remain <= remain - 1'b1;
            end
         end
         assign ready = (remain == '0);
      end
   endgenerate
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]                                req,
   input  logic [barrel_sched_pkg::cnt_width(N)-1:0]   start,
   output logic                                        found,
   output logic [barrel_sched_pkg::cnt_width(N)-1:0]   pick
);
   localparam int unsigned TW = barrel_sched_pkg::cnt_width(N);

   logic [TW:0] cand;

   always_comb begin
      found = 1'b0;
      pick  = '0;
      cand  = '0;
      for (int k = 0; k < N; k++) begin
         cand = {1'b0, start} + (TW+1)'(k);
         if (cand >= (TW+1)'(N)) cand = cand - (TW+1)'(N);
         if (!found && req[cand[TW-1:0]]) begin
            found = 1'b1;
            pick  = cand[TW-1:0];
         end
      end
   end
endmodule

// File: rtl/barrel_sched.sv
module barrel_sched #(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned PIPE_DEPTH  = 4
) (
   input  logic                                              clk,
   input  logic                                              rst,
   input  logic [NUM_THREADS-1:0]                            thread_active,
   output logic                                              issue_valid,
   output logic [barrel_sched_pkg::cnt_width(NUM_THREADS)-1:0] issue_tid
);
   localparam int unsigned TW = barrel_sched_pkg::cnt_width(NUM_THREADS);

   generate
      if (NUM_THREADS < barrel_sched_pkg::MIN_THREADS ||
          NUM_THREADS > barrel_sched_pkg::MAX_THREADS) begin : g_bad_threads
         $error("barrel_sched: NUM_THREADS out of range");
      end
      if (PIPE_DEPTH < 1) begin : g_bad_depth
         $error("barrel_sched: PIPE_DEPTH must be at least 1");
      end
   endgenerate

   logic [NUM_THREADS-1:0] cool_ok;
   logic [NUM_THREADS-1:0] eligible;
   logic [NUM_THREADS-1:0] grant_oh;
   logic [TW-1:0]          rot_ptr;
   logic                   any_grant;
   logic [TW-1:0]          grant_idx;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         assign grant_oh[t] = any_grant && (grant_idx == TW'(t));
         thread_cooldown #(.PIPE_DEPTH(PIPE_DEPTH)) u_cool (
            .clk    (clk),
            .rst    (rst),
            .issued (grant_oh[t]),
            .ready  (cool_ok[t])
         );
      end
   endgenerate

   assign eligible = thread_active & cool_ok;

   rr_picker #(.N(NUM_THREADS)) u_pick (
      .req   (eligible),
      .start (rot_ptr),
      .found (any_grant),
      .pick  (grant_idx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rot_ptr <= '0;
      end else if (any_grant) begin
         rot_ptr <= (grant_idx == TW'(NUM_THREADS - 1)) ? '0 : grant_idx + 1'b1;
      end
   end

   assign issue_valid = any_grant;
   assign issue_tid   = grant_idx;
endmodule

// File: rtl/barrel_sched_chk.sv
module barrel_sched_chk #(
   parameter int unsigned NUM_THREADS = 8,
   parameter int unsigned PIPE_DEPTH  = 4
) (
   input logic                                                clk,
   input logic                                                rst,
   input logic [NUM_THREADS-1:0]                              thread_active,
   input logic                                                issue_valid,
   input logic [barrel_sched_pkg::cnt_width(NUM_THREADS)-1:0] issue_tid
);
   localparam int unsigned TW = barrel_sched_pkg::cnt_width(NUM_THREADS);
   localparam int unsigned SW = $clog2(PIPE_DEPTH + 1) + 1;

   logic [NUM_THREADS-1:0] waiting;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_c
         logic [SW-1:0] since;
         logic          hit;
         assign hit = issue_valid && (issue_tid == TW'(t));
         always_ff @(posedge clk) begin
            if (rst)                           since <= SW'(PIPE_DEPTH);
            else if (hit)                      since <= SW'(1);
            else if (since < SW'(PIPE_DEPTH))  since <= since + 1'b1;
         end
         assign waiting[t] = thread_active[t] && (since >= SW'(PIPE_DEPTH));

         // R2: spacing of a thread's issues
         p_spacing_r2: assert property (@(posedge clk) disable iff (rst)
            hit |-> (since >= SW'(PIPE_DEPTH)));
      end
   endgenerate

   // R6: only enabled threads are granted
   p_active_only_r6: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> thread_active[issue_tid]);

   // R8: no bubble while an enabled thread is ready
   p_no_idle_r8: assert property (@(posedge clk) disable iff (rst)
      (|waiting) |-> issue_valid);

   // R1: nothing issues without an enabled thread
   p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      (thread_active == '0) |-> !issue_valid);

   // R6: index stays within the thread count
   p_tid_range_r6: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> (issue_tid <= TW'(NUM_THREADS - 1)));
endmodule

bind barrel_sched barrel_sched_chk #(
   .NUM_THREADS(NUM_THREADS),
   .PIPE_DEPTH (PIPE_DEPTH)
) u_chk (.*);

// File: tb/barrel_sched_test.sv
module barrel_sched_test;
   localparam int NT = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NT-1:0] act = '0;
   logic          iv;
   logic [2:0]    tid;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   barrel_sched #(.NUM_THREADS(NT), .PIPE_DEPTH(4)) uut (
      .clk(clk), .rst(rst), .thread_active(act),
      .issue_valid(iv), .issue_tid(tid)
   );

   localparam logic [7:0] VEC [8] = '{8'hFF, 8'h1F, 8'h7E, 8'h0F,
                                      8'hA5, 8'h92, 8'h03, 8'h01};

   task automatic chk(input string req, input bit ev, input int et);
      n_run++;
      if (iv !== ev || (ev && tid !== et[2:0])) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                  req, iv, tid, ev, et);
      end
   endtask

   // Hold reset with no enabled thread, release at a negedge with mask m.
   task automatic restart(input logic [7:0] m);
      @(negedge clk); rst = 1'b1; act = '0;
      @(negedge clk);
      @(negedge clk); rst = 1'b0; act = m;
      #2;
   endtask

   task automatic next(input logic [7:0] m);
      @(negedge clk); act = m; #2;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state with nothing enabled
      @(negedge clk); #2;
      chk("R1 during reset", 1'b0, 0);
      restart(8'h00);
      chk("R1 idle after reset", 1'b0, 0);
      next(8'h00);
      chk("R6 no enable, no issue", 1'b0, 0);

      // Vector table walk: fixed masks
      for (int v = 0; v < 8; v++) begin
         int lst[8];
         int n;
         int last[8];
         bit contig;
         string tag;
         n = 0;
         for (int i = 0; i < 8; i++) begin
            last[i] = -100;
            if (VEC[v][i]) begin lst[n] = i; n++; end
         end
         contig = ((VEC[v] & (VEC[v] + 8'd1)) == 8'd0) ||
                  (VEC[v] == 8'h7E) || (VEC[v] == 8'h1F);
         tag = !contig ? "R5" : (n >= 5 ? "R4" : "R3");
         restart(VEC[v]);
         for (int k = 0; k < 16; k++) begin
            bit ev;
            int et;
            if (k > 0) next(VEC[v]);
            if (n >= 4) begin ev = 1'b1; et = lst[k % n]; end
            else begin
               ev = ((k % 4) < n);
               et = ev ? lst[k % 4] : 0;
            end
            chk(k == 0 ? "R1 first grant" : tag, ev, et);
            if (iv) begin
               n_run++;
               if (k - last[tid] < 4) begin
                  n_fail++;
                  $display("FAIL R2: got gap %0d for thread %0d, expected >= 4",
                           k - last[tid], tid);
               end
               last[tid] = k;
            end
         end
      end

      // R6: drop thread 3 in the cycle the rotation would pick it
      restart(8'hFF);
      chk("R6 c0", 1'b1, 0);
      next(8'hFF); chk("R6 c1", 1'b1, 1);
      next(8'hFF); chk("R6 c2", 1'b1, 2);
      next(8'hF7); chk("R6 dropped thread skipped", 1'b1, 4);
      next(8'hF7); chk("R6 rotation continues", 1'b1, 5);

      // R7: re-enable before cooldown ends
      restart(8'h03);
      chk("R7 c0", 1'b1, 0);
      next(8'h03); chk("R7 c1", 1'b1, 1);
      next(8'h02); chk("R7 c2 bubble", 1'b0, 0);
      next(8'h03); chk("R7 cooldown still running", 1'b0, 0);
      next(8'h03); chk("R7 eligible after four clocks", 1'b1, 0);

      // R8: newly enabled thread that never issued
      restart(8'h01);
      chk("R8 c0", 1'b1, 0);
      next(8'h01); chk("R3 single thread bubble", 1'b0, 0);
      next(8'h03); chk("R8 new thread at once", 1'b1, 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule